// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block holds a small set of recent translations from virtual page numbers to physical frame numbers. A lookup presents a 32-bit virtual address; the upper 20 bits are compared against every stored entry at once, and on a match the frame number, joined with the untouched 12-bit page offset, comes back in the same cycle. When nothing matches, the block raises a miss so that an outside page-table walker can fetch the translation and hand it back through the fill port.

Each entry also carries a modified flag. A write lookup that hits sets it. When a modified entry is about to be dropped, the block raises a one-cycle write-back request carrying the entry's page number. An entry is dropped when a fill replaces it, when it is invalidated by page number, or when everything is flushed on a context switch. A policy input selects the victim when every slot is occupied. One setting takes the least recently used entry, tracked with per-entry age ranks. The other takes a pseudo-random slot drawn from a free-running shift register. Free slots are always used before any valid entry is replaced.

Top module: `tlb_top`

## Requirements
- R1: A lookup whose page number matches a valid entry raises `hit` in the same cycle, with `physAddr` equal to the stored frame number in bits 31:12 and the lookup offset in bits 11:0.
- R2: A lookup whose page number matches no valid entry raises `miss` and leaves `hit` low.
- R3: A fill whose page number is already held overwrites that entry in place, leaving no duplicate. Any other fill goes to the lowest-numbered invalid slot while one exists.
- R4: With `useLru` high and every slot valid, a fill replaces the entry whose most recent hit or fill is the oldest.
- R5: With `useLru` low and every slot valid, a fill replaces exactly one pseudo-randomly chosen entry. All other translations survive.
- R6: A write lookup that hits sets the entry's modified flag. A fill that replaces a modified entry raises `wbValid` for that one cycle with `wbVpn` set to the replaced page number. A fill that replaces a clean entry raises no write-back.
- R7: An invalidate removes the matching entry and, if that entry is modified, raises `wbValid` in the same cycle with its page number. An invalidate of a page that is not held changes nothing.
- R8: A flush request makes `busy` high from the next cycle. The block then issues one write-back per cycle for each modified entry, in ascending slot order, and spends one further cycle clearing every entry, after which `busy` falls. While `busy` is high, lookups report neither hit nor miss, and fills and invalidates are ignored.
- R9: When more than one of flush, invalidate and fill arrive in the same cycle, flush wins over invalidate and invalidate wins over fill. The losing request is dropped.
- R10: A lookup in the same cycle as an invalidate or fill sees the entries as they stood before that edge. A write hit on the entry being dropped in that cycle causes a write-back even if the entry was clean.
- R11: After reset, all entries are invalid, `busy` is low and `wbValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookValid | input | 1 | Lookup request this cycle |
| lookWrite | input | 1 | Lookup is a store access |
| lookAddr | input | 32 | Virtual address to translate |
| hit | output | 1 | Lookup matched a valid entry |
| miss | output | 1 | Lookup matched nothing; refill needed |
| physAddr | output | 32 | Translated address, zero when no hit |
| fillValid | input | 1 | Load a translation this cycle |
| fillVpn | input | 20 | Page number to load |
| fillPfn | input | 20 | Frame number to load |
| fillDirty | input | 1 | Initial modified flag of the loaded entry |
| invValid | input | 1 | Invalidate one page this cycle |
| invVpn | input | 20 | Page number to invalidate |
| flushReq | input | 1 | Start a flush of all entries |
| useLru | input | 1 | 1: least recently used victim, 0: pseudo-random victim |
| busy | output | 1 | Flush in progress |
| wbValid | output | 1 | Write-back of a modified entry this cycle |
| wbVpn | output | 20 | Page number being written back |

## Verification
The collision that matters is a lookup landing in the same cycle as an invalidate or fill that drops the very entry being looked up. The bench provokes it by issuing a store lookup and an invalidate of the same clean page together. It judges the result by requiring a hit carrying the old frame in that cycle and a write-back of that page in the same cycle, followed by a miss on the next lookup. A second collision is the flush: a lookup and a fill are driven into its first busy cycle, and the bench requires silence on hit and miss and loss of the fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Strobes sent from control to datapath, at most one action per cycle
  // apart from the lookup touch.
  typedef struct packed {
    logic hitEn;      // lookup hit may update recency and modified flag
    logic invEn;      // perform an invalidate
    logic fillEn;     // perform a fill
    logic flushWbEn;  // write back the lowest modified entry
    logic clearAll;   // drop every entry
  } tlbStrobe_t;

  typedef enum logic {ST_RUN, ST_FLUSH} tlbState_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lookValid,
  input  logic       lookHitRaw,
  input  logic       fillValid,
  input  logic       invValid,
  input  logic       flushReq,
  input  logic       anyDirty,
  output tlbStrobe_t strobe,
  output logic       busy
);

  tlbState_t stateQ, stateD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    if (stateQ == ST_RUN) begin
      strobe.hitEn = lookValid && lookHitRaw;
      if (flushReq) begin
        stateD = ST_FLUSH;
      end else if (invValid) begin
        strobe.invEn = 1'b1;
      end else if (fillValid) begin
        strobe.fillEn = 1'b1;
      end
    end else begin
      if (anyDirty) begin
        strobe.flushWbEn = 1'b1;
      end else begin
        strobe.clearAll = 1'b1;
        stateD = ST_RUN;
      end
    end
  end

  assign busy = (stateQ == ST_FLUSH);

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  // R8: a flush request taken while running makes the block busy next cycle
  assert_flush_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && flushReq) |=> busy);

  // R8: once no modified entry is left, busy drops after the clearing cycle
  assert_flush_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !anyDirty) |=> !busy);

endmodule

// File: rtl/tlb_dp.sv
module tlb_dp
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
)(
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic             useLru,
  input  logic [VPN_W-1:0] lookVpn,
  input  logic             lookWrite,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillDirty,
  input  logic [VPN_W-1:0] invVpn,
  output logic             lookHitRaw,
  output logic [PFN_W-1:0] hitPfn,
  output logic             anyDirty,
  output logic             wbValid,
  output logic [VPN_W-1:0] wbVpn
);

  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [IDX_W-1:0]  AGE_OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] validQ, dirtyQ;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PFN_W-1:0]   pfnQ [ENTRIES];
  logic [IDX_W-1:0]   ageQ [ENTRIES];
  logic [LFSR_W-1:0]  lfsrQ;

  logic [ENTRIES-1:0] lookMatch, fillMatch, invMatch, dirtyValid;

  // Parallel comparators, one per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookMatch[g]  = validQ[g] && (vpnQ[g] == lookVpn);
    assign fillMatch[g]  = validQ[g] && (vpnQ[g] == fillVpn);
    assign invMatch[g]   = validQ[g] && (vpnQ[g] == invVpn);
    assign dirtyValid[g] = validQ[g] && dirtyQ[g];
  end

  logic [IDX_W-1:0] hitIdx, fillIdx, invIdx, freeIdx, dirtyIdx, lruIdx, randIdx;
  logic             fillHit, invHit, anyFree;

  always_comb begin
    hitIdx   = '0;
    fillIdx  = '0;
    invIdx   = '0;
    freeIdx  = '0;
    dirtyIdx = '0;
    lruIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lookMatch[i])  hitIdx   = IDX_W'(i);
      if (fillMatch[i])  fillIdx  = IDX_W'(i);
      if (invMatch[i])   invIdx   = IDX_W'(i);
      if (!validQ[i])    freeIdx  = IDX_W'(i);
      if (dirtyValid[i]) dirtyIdx = IDX_W'(i);
      if (ageQ[i] == AGE_OLDEST) lruIdx = IDX_W'(i);
    end
  end

  assign lookHitRaw = |lookMatch;
  assign fillHit    = |fillMatch;
  assign invHit     = |invMatch;
  assign anyFree    = ~&validQ;
  assign anyDirty   = |dirtyValid;
  assign hitPfn     = pfnQ[hitIdx];
  assign randIdx    = IDX_W'(32'(lfsrQ) % ENTRIES);

  // Victim choice: same page, then free slot, then policy
  logic [IDX_W-1:0] victimIdx;
  always_comb begin
    if (fillHit)      victimIdx = fillIdx;
    else if (anyFree) victimIdx = freeIdx;
    else if (useLru)  victimIdx = lruIdx;
    else              victimIdx = randIdx;
  end

  logic writeTouch, victimNeedWb, invNeedWb;
  assign writeTouch   = strobe.hitEn && lookWrite;
  assign victimNeedWb = validQ[victimIdx] &&
                        (dirtyQ[victimIdx] || (writeTouch && hitIdx == victimIdx));
  assign invNeedWb    = invHit &&
                        (dirtyQ[invIdx] || (writeTouch && hitIdx == invIdx));

  always_comb begin
    wbValid = 1'b0;
    wbVpn   = '0;
    if (strobe.flushWbEn) begin
      wbValid = 1'b1;
      wbVpn   = vpnQ[dirtyIdx];
    end else if (strobe.invEn && invNeedWb) begin
      wbValid = 1'b1;
      wbVpn   = vpnQ[invIdx];
    end else if (strobe.fillEn && victimNeedWb) begin
      wbValid = 1'b1;
      wbVpn   = vpnQ[victimIdx];
    end
  end

  // Recency: a fill takes precedence over a lookup hit in the same cycle
  logic             touchEn;
  logic [IDX_W-1:0] touchIdx, touchAge;
  always_comb begin
    touchEn  = strobe.fillEn || strobe.hitEn;
    touchIdx = strobe.fillEn ? victimIdx : hitIdx;
    touchAge = ageQ[touchIdx];
  end

  logic [LFSR_W-1:0] lfsrD;
  assign lfsrD = {lfsrQ[LFSR_W-2:0], lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      lfsrQ  <= LFSR_SEED;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i] <= '0;
        pfnQ[i] <= '0;
        ageQ[i] <= IDX_W'(i);
      end
    end else begin
      lfsrQ <= lfsrD;
      if (strobe.clearAll) begin
        validQ <= '0;
        dirtyQ <= '0;
      end
      if (strobe.flushWbEn) dirtyQ[dirtyIdx] <= 1'b0;
      if (writeTouch)       dirtyQ[hitIdx]   <= 1'b1;
      if (strobe.invEn && invHit) begin
        validQ[invIdx] <= 1'b0;
        dirtyQ[invIdx] <= 1'b0;
      end
      if (strobe.fillEn) begin
        validQ[victimIdx] <= 1'b1;
        dirtyQ[victimIdx] <= fillDirty;
        vpnQ[victimIdx]   <= fillVpn;
        pfnQ[victimIdx]   <= fillPfn;
      end
      if (touchEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx)  ageQ[i] <= '0;
          else if (ageQ[i] < touchAge) ageQ[i] <= ageQ[i] + 1'b1;
        end
      end
    end
  end

  // R3: no page is ever held in two slots
  assert_unique_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch));

  // R3: a fill leaves the page resident in the slot it chose
  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> (validQ[$past(victimIdx)] && vpnQ[$past(victimIdx)] == $past(fillVpn)));

  // R6: a write hit not overridden by a drop leaves the entry modified
  assert_write_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (writeTouch && !(strobe.fillEn && victimIdx == hitIdx)
                && !(strobe.invEn && invHit && invIdx == hitIdx))
    |=> dirtyQ[$past(hitIdx)]);

  // R8: the clearing step of a flush empties the whole buffer
  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (validQ == '0));

  // R8: each flush write-back retires one modified entry
  assert_flush_wb_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushWbEn |=> ($countones(dirtyValid) == $countones($past(dirtyValid)) - 1));

endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookValid,
  input  logic             lookWrite,
  input  logic [VA_W-1:0]  lookAddr,
  output logic             hit,
  output logic             miss,
  output logic [PA_W-1:0]  physAddr,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillDirty,
  input  logic             invValid,
  input  logic [VPN_W-1:0] invVpn,
  input  logic             flushReq,
  input  logic             useLru,
  output logic             busy,
  output logic             wbValid,
  output logic [VPN_W-1:0] wbVpn
);

  tlbStrobe_t       strobe;
  logic             lookHitRaw, anyDirty;
  logic [PFN_W-1:0] hitPfn;

  tlb_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lookValid  (lookValid),
    .lookHitRaw (lookHitRaw),
    .fillValid  (fillValid),
    .invValid   (invValid),
    .flushReq   (flushReq),
    .anyDirty   (anyDirty),
    .strobe     (strobe),
    .busy       (busy)
  );

  tlb_dp #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .useLru     (useLru),
    .lookVpn    (lookAddr[VA_W-1:OFF_W]),
    .lookWrite  (lookWrite),
    .fillVpn    (fillVpn),
    .fillPfn    (fillPfn),
    .fillDirty  (fillDirty),
    .invVpn     (invVpn),
    .lookHitRaw (lookHitRaw),
    .hitPfn     (hitPfn),
    .anyDirty   (anyDirty),
    .wbValid    (wbValid),
    .wbVpn      (wbVpn)
  );

  assign hit      = lookValid && lookHitRaw && !busy;
  assign miss     = lookValid && !lookHitRaw && !busy;
  assign physAddr = hit ? {hitPfn, lookAddr[OFF_W-1:0]} : '0;

  // R8: nothing is written back outside a flush unless a drop was requested
  assert_wb_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !busy) |-> (invValid || fillValid));

endmodule

// File: tb/test_tlb_top.sv
module test_tlb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] OFFS = 12'hABC;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lookValid, lookWrite;
  logic [31:0] lookAddr;
  logic        hit, miss;
  logic [31:0] physAddr;
  logic        fillValid, fillDirty;
  logic [19:0] fillVpn, fillPfn;
  logic        invValid;
  logic [19:0] invVpn;
  logic        flushReq, useLru;
  logic        busy, wbValid;
  logic [19:0] wbVpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_top i_tlb_top (
    .clk(clk), .rstN(rstN),
    .lookValid(lookValid), .lookWrite(lookWrite), .lookAddr(lookAddr),
    .hit(hit), .miss(miss), .physAddr(physAddr),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn), .fillDirty(fillDirty),
    .invValid(invValid), .invVpn(invVpn),
    .flushReq(flushReq), .useLru(useLru),
    .busy(busy), .wbValid(wbValid), .wbVpn(wbVpn)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle's inputs at the falling edge; outputs are sampled 1 time unit later
  task automatic step(input bit lv, input bit lw, input logic [19:0] lvpn,
                      input bit fv, input logic [19:0] fvpn, input logic [19:0] fpfn,
                      input bit fd, input bit iv, input logic [19:0] ivpn, input bit fl);
    @(negedge clk);
    lookValid = lv; lookWrite = lw; lookAddr = {lvpn, OFFS};
    fillValid = fv; fillVpn = fvpn; fillPfn = fpfn; fillDirty = fd;
    invValid = iv; invVpn = ivpn; flushReq = fl;
    #1;
  endtask

  task automatic look(input logic [19:0] v, input bit wr);
    step(1'b1, wr, v, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask
  task automatic fill(input logic [19:0] v, input logic [19:0] p);
    step(1'b0, 1'b0, '0, 1'b1, v, p, 1'b0, 1'b0, '0, 1'b0);
  endtask
  task automatic idle();
    step(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  // Vector table: op 0 read lookup, 1 write lookup, 2 fill, 3 invalidate
  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [19:0] pfn;
    logic        expHit;
    logic        expMiss;
    logic [19:0] expPfn;
    logic        expWb;
    logic [19:0] expWbVpn;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    {2'd0, 20'h12345, 20'h00000, 1'b0, 1'b1, 20'h00000, 1'b0, 20'h00000, 4'd2},  // R2 empty miss
    {2'd2, 20'h12345, 20'h01000, 1'b0, 1'b0, 20'h00000, 1'b0, 20'h00000, 4'd3},  // R3 fill slot 0
    {2'd0, 20'h12345, 20'h00000, 1'b1, 1'b0, 20'h01000, 1'b0, 20'h00000, 4'd1},  // R1 hit
    {2'd2, 20'h00007, 20'h0AAAA, 1'b0, 1'b0, 20'h00000, 1'b0, 20'h00000, 4'd3},  // R3 fill slot 1
    {2'd0, 20'h00007, 20'h00000, 1'b1, 1'b0, 20'h0AAAA, 1'b0, 20'h00000, 4'd1},  // R1
    {2'd0, 20'h00008, 20'h00000, 1'b0, 1'b1, 20'h00000, 1'b0, 20'h00000, 4'd2},  // R2
    {2'd1, 20'h00007, 20'h00000, 1'b1, 1'b0, 20'h0AAAA, 1'b0, 20'h00000, 4'd6},  // R6 write hit
    {2'd3, 20'h00007, 20'h00000, 1'b0, 1'b0, 20'h00000, 1'b1, 20'h00007, 4'd7},  // R7 dirty inv
    {2'd0, 20'h00007, 20'h00000, 1'b0, 1'b1, 20'h00000, 1'b0, 20'h00000, 4'd7},  // R7 gone
    {2'd3, 20'h00055, 20'h00000, 1'b0, 1'b0, 20'h00000, 1'b0, 20'h00000, 4'd7},  // R7 absent
    {2'd0, 20'h12345, 20'h00000, 1'b1, 1'b0, 20'h01000, 1'b0, 20'h00000, 4'd7},  // R7 untouched
    {2'd2, 20'h12345, 20'h02000, 1'b0, 1'b0, 20'h00000, 1'b0, 20'h00000, 4'd3},  // R3 overwrite
    {2'd0, 20'h12345, 20'h00000, 1'b1, 1'b0, 20'h02000, 1'b0, 20'h00000, 4'd3},  // R3 new frame
    {2'd2, 20'h00009, 20'h00900, 1'b0, 1'b0, 20'h00000, 1'b0, 20'h00000, 4'd3},  // R3 refill
    {2'd3, 20'h12345, 20'h00000, 1'b0, 1'b0, 20'h00000, 1'b0, 20'h00000, 4'd7},  // R7 clean inv
    {2'd0, 20'h12345, 20'h00000, 1'b0, 1'b1, 20'h00000, 1'b0, 20'h00000, 4'd7}   // R7
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; useLru = 1'b1;
    lookValid = 0; lookWrite = 0; lookAddr = '0;
    fillValid = 0; fillVpn = '0; fillPfn = '0; fillDirty = 0;
    invValid = 0; invVpn = '0; flushReq = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 busy in reset", 32'(busy), 32'd0);
    check("R11 wb in reset", 32'(wbValid), 32'd0);
    @(negedge clk) rstN = 1'b1;
    look(20'h00000, 1'b0);
    check("R11 empty after reset", {30'd0, hit, miss}, 32'd1);

    // Table walk
    for (int k = 0; k < NVEC; k++) begin
      vec_t v = VECS[k];
      case (v.op)
        2'd0: look(v.vpn, 1'b0);
        2'd1: look(v.vpn, 1'b1);
        2'd2: fill(v.vpn, v.pfn);
        default: step(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b1, v.vpn, 1'b0);
      endcase
      checks++;
      if (hit !== v.expHit || miss !== v.expMiss || wbValid !== v.expWb ||
          (v.expHit && physAddr !== {v.expPfn, OFFS}) ||
          (v.expWb && wbVpn !== v.expWbVpn)) begin
        fails++;
        $display("FAIL R%0d vec %0d actual hit%b miss%b pa%h wb%b/%h expected hit%b miss%b pa%h wb%b/%h",
                 v.req, k, hit, miss, physAddr, wbValid, wbVpn,
                 v.expHit, v.expMiss, {v.expPfn, OFFS}, v.expWb, v.expWbVpn);
      end
    end

    // R8 flush with nothing modified: one busy cycle
    step(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1);
    idle();
    check("R8 busy clean flush", {30'd0, busy, wbValid}, 32'd2);
    idle();
    check("R8 busy falls", 32'(busy), 32'd0);
    look(20'h00009, 1'b0);
    check("R8 flushed miss", 32'(miss), 32'd1);

    // R4 least recently used replacement
    useLru = 1'b1;
    for (int i = 0; i < 16; i++) fill(20'h100 + 20'(i), 20'h900 + 20'(i));
    look(20'h100, 1'b0);
    check("R4 hit oldest", 32'(hit), 32'd1);
    fill(20'h200, 20'hA00);
    check("R6 clean victim no wb", 32'(wbValid), 32'd0);
    look(20'h101, 1'b0);
    check("R4 lru evicted", 32'(miss), 32'd1);
    look(20'h100, 1'b0);
    check("R4 touched kept", 32'(hit), 32'd1);
    look(20'h200, 1'b0);
    check("R4 new entry", physAddr, {20'hA00, OFFS});
    look(20'h102, 1'b0);
    check("R4 others kept", 32'(hit), 32'd1);

    // R6 replacing a modified entry
    look(20'h103, 1'b1);
    fill(20'h103, 20'hB03);
    check("R6 dirty replace wb", {11'd0, wbValid, wbVpn}, {11'd0, 1'b1, 20'h103});
    look(20'h103, 1'b0);
    check("R6 replaced frame", physAddr, {20'hB03, OFFS});

    // R10 write lookup colliding with invalidate of the same clean page
    step(1'b1, 1'b1, 20'h105, 1'b0, '0, '0, 1'b0, 1'b1, 20'h105, 1'b0);
    check("R10 old contents visible", physAddr, {20'h905, OFFS});
    check("R10 collision wb", {11'd0, wbValid, wbVpn}, {11'd0, 1'b1, 20'h105});
    look(20'h105, 1'b0);
    check("R10 dropped", 32'(miss), 32'd1);

    // R9 invalidate beats fill
    step(1'b0, 1'b0, '0, 1'b1, 20'h300, 20'hC00, 1'b0, 1'b1, 20'h106, 1'b0);
    check("R9 clean inv no wb", 32'(wbValid), 32'd0);
    look(20'h106, 1'b0);
    check("R9 inv applied", 32'(miss), 32'd1);
    look(20'h300, 1'b0);
    check("R9 fill dropped", 32'(miss), 32'd1);

    // R8 flush with two modified entries, slots 7 and 8
    look(20'h107, 1'b1);
    look(20'h108, 1'b1);
    step(1'b0, 1'b0, '0, 1'b1, 20'h301, 20'hC01, 1'b0, 1'b0, '0, 1'b1);
    check("R9 flush beats fill", 32'(wbValid), 32'd0);
    step(1'b1, 1'b0, 20'h100, 1'b1, 20'h302, 20'hC02, 1'b0, 1'b0, '0, 1'b0);
    check("R8 first wb", {10'd0, busy, wbValid, wbVpn}, {10'd0, 2'b11, 20'h107});
    check("R8 lookup silent", {30'd0, hit, miss}, 32'd0);
    idle();
    check("R8 second wb", {10'd0, busy, wbValid, wbVpn}, {10'd0, 2'b11, 20'h108});
    idle();
    check("R8 clearing cycle", {30'd0, busy, wbValid}, 32'd2);
    idle();
    check("R8 done", 32'(busy), 32'd0);
    look(20'h100, 1'b0);
    check("R8 all cleared", 32'(miss), 32'd1);
    look(20'h302, 1'b0);
    check("R8 fill during busy ignored", 32'(miss), 32'd1);

    // R5 pseudo-random replacement loses exactly one translation
    useLru = 1'b0;
    for (int i = 0; i < 16; i++) fill(20'h400 + 20'(i), 20'hD00 + 20'(i));
    fill(20'h500, 20'hE00);
    begin
      int hits = 0;
      for (int i = 0; i < 16; i++) begin
        look(20'h400 + 20'(i), 1'b0);
        if (hit) hits++;
      end
      check("R5 survivors", 32'(hits), 32'd15);
    end
    look(20'h500, 1'b0);
    check("R5 new resident", physAddr, {20'hE00, OFFS});

    idle();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule